// File: doc/BRIEF.md
# DDR3 Burst Column Sequencer

This block turns a registered column command (READ or WRITE) into the ordered list of column offsets that a burst walks through. With the command it receives the three low column bits and the two command-time flags: auto-precharge request and on-the-fly chop select. Using the burst settings held in the mode configuration, it decides whether the burst runs 8 beats or a chopped 4 beats. It then presents the beat offsets two at a time, one even beat and one odd beat per clock. This matches an internal core that moves one double-width prefetch word per clock while the pins move one beat per half clock.

Once a burst has started, the ordering, length and auto-precharge choice stay fixed for it. A new command may arrive on the final beat pair, and its burst then follows with no gap. A command that arrives earlier is dropped and reported. Bank and row decode and the strobe and data pins belong to other blocks.

Top module: `ddr_burst_colgen`

## Requirements
- R1: After synchronous reset, `burst_active`, `cmd_err`, `ap_out` and `last_pair` are low and `beat_count` is 0.
- R2: A command that is accepted in cycle t starts a burst whose pair 0 appears in cycle t+1. A BL8 burst then keeps `burst_active` high for 4 consecutive cycles with `pair_idx` 0,1,2,3, and a BC4 burst for 2 cycles with `pair_idx` 0,1. `last_pair` is high on the final one.
- R3: `cfg_bl_mode` selects the length: 2'b00 is fixed 8 beats and 2'b10 is fixed 4 beats. With 2'b01 or 2'b11, `cmd_a12`=1 gives 8 beats and 0 gives 4. While a burst is active, `beat_count` shows 8 or 4, and it is 0 when idle.
- R4: For a read with `cfg_interleave`=0, beat b (0..7) has offset {s[2]^b[2], s[1:0]+b[1:0] mod 4}, where s is `cmd_col`. Pair p carries beat 2p on `off_even` and beat 2p+1 on `off_odd`.
- R5: For a read with `cfg_interleave`=1, beat b has offset s XOR b.
- R6: For a write, s[1:0] is taken as 0 and the R4 sequential rule applies whatever the value of `cfg_interleave`.
- R7: `ap_out` is high on the last pair of a burst whose command had `cmd_a10`=1, and low on every other cycle.
- R8: A command that arrives on the last pair is accepted, and its pair 0 follows in the next cycle.
- R9: A command that arrives while a burst is active and not on its last pair is dropped. `cmd_err` is high for exactly the next cycle, and the running burst carries on unchanged.
- R10: Length mode, ordering, write flag, start and auto-precharge are captured when the command is accepted. Later changes to `cfg_*` do not affect a burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one beat pair per cycle |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Column command present this cycle |
| cmd_write | input | 1 | 1 = WRITE, 0 = READ |
| cmd_col | input | 3 | Low column bits, burst start |
| cmd_a10 | input | 1 | Auto-precharge request |
| cmd_a12 | input | 1 | On-the-fly length: 1 = 8 beats, 0 = 4 |
| cfg_bl_mode | input | 2 | Burst length mode (see R3) |
| cfg_interleave | input | 1 | Read ordering: 1 = interleaved |
| burst_active | output | 1 | A beat pair is presented this cycle |
| pair_idx | output | 2 | Index of the current beat pair |
| last_pair | output | 1 | Final pair of the burst |
| beat_count | output | 4 | 8 or 4 during a burst, 0 idle |
| off_even | output | 3 | Column offset of beat 2*pair_idx |
| off_odd | output | 3 | Column offset of beat 2*pair_idx+1 |
| ap_out | output | 1 | Auto-precharge due at burst end |
| write_burst | output | 1 | Current burst is a write |
| cmd_err | output | 1 | Previous cycle's command was rejected |

## Verification
The bench goes after nibble wrap on odd start columns. A design that carried into bit 2 would produce, for example, 5,6,7,0 instead of 5,6,7,4 for the first nibble. It also sends writes with interleave set and non-zero low column bits, where a design that failed to clear those bits or ignored the write flag would give rotated offsets. Commands land on every pair position, so a design that accepted them one pair too early would truncate the running burst, and one that accepted them too late would leave a one-cycle gap or raise a false error. The configuration changes on every cycle, so a design that read it live instead of capturing it would change length or ordering in the middle of a burst.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
    localparam int OFF_W   = 3;
    localparam int LANES   = 2;
    localparam int PAIR_W  = 2;
    localparam int CNT_W   = 4;
    localparam int BEATS_LONG  = 8;
    localparam int BEATS_SHORT = 4;

    typedef enum logic [1:0] {
        BLM_FIX8 = 2'b00,
        BLM_OTF  = 2'b01,
        BLM_FIX4 = 2'b10,
        BLM_OTFB = 2'b11
    } blmode_e;

    typedef struct packed {
        logic             len8;
        logic             ilv;
        logic             wr;
        logic             ap;
        logic [OFF_W-1:0] start;
    } burst_desc_t;

    function automatic logic [OFF_W-1:0] seq_off(input logic [OFF_W-1:0] s,
                                                 input logic [OFF_W-1:0] b);
        logic [1:0] lo;
        lo = s[1:0] + b[1:0];
        return {s[2] ^ b[2], lo};
    endfunction

    function automatic logic [OFF_W-1:0] ilv_off(input logic [OFF_W-1:0] s,
                                                 input logic [OFF_W-1:0] b);
        return s ^ b;
    endfunction
endpackage

// File: rtl/bcg_decode.sv
module bcg_decode
    import bcg_pkg::*;
(
    input  logic             is_write,
    input  logic [OFF_W-1:0] col,
    input  logic             a10,
    input  logic             a12,
    input  logic [1:0]       bl_mode,
    input  logic             ilv,
    output burst_desc_t      desc
);
    blmode_e mode;
    always_comb begin
        mode = blmode_e'(bl_mode);
        desc = '0;
        unique case (mode)
            BLM_FIX8: desc.len8 = 1'b1;
            BLM_FIX4: desc.len8 = 1'b0;
            default:  desc.len8 = a12;
        endcase
        desc.wr  = is_write;
        desc.ap  = a10;
        desc.ilv = is_write ? 1'b0 : ilv;
        desc.start = is_write ? {col[OFF_W-1], 2'b00} : col;
    end
endmodule

// File: rtl/bcg_seq.sv
module bcg_seq
    import bcg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  burst_desc_t       desc_in,
    output logic              active,
    output logic [PAIR_W-1:0] pair,
    output logic              last,
    output logic              err,
    output burst_desc_t       desc_q
);
    localparam logic [PAIR_W-1:0] LAST8 = PAIR_W'(BEATS_LONG / LANES - 1);
    localparam logic [PAIR_W-1:0] LAST4 = PAIR_W'(BEATS_SHORT / LANES - 1);

    logic accept;

    assign last   = active && (pair == (desc_q.len8 ? LAST8 : LAST4));
    assign accept = cmd_valid && (!active || last);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            pair   <= '0;
            err    <= 1'b0;
            desc_q <= '0;
        end else begin
            err <= cmd_valid && active && !last;
            if (accept) begin
                active <= 1'b1;
                pair   <= '0;
                desc_q <= desc_in;
            end else if (active) begin
                if (last) begin
                    active <= 1'b0;
                    pair   <= '0;
                end else begin
                    pair <= pair + 1'b1;
                end
            end
        end
    end

    assert_accept_start_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (!active || last)) |=> (active && pair == '0));

    assert_reject_keeps_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && active && !last) |=> (err && active && pair == $past(pair) + 1'b1
                                             && desc_q == $past(desc_q)));

    assert_short_len_R3: assert property (@(posedge clk) disable iff (rst)
        (active && !desc_q.len8) |-> (pair < 2'd2));

    assert_hold_cfg_R10: assert property (@(posedge clk) disable iff (rst)
        (active && !last) |=> $stable(desc_q));
endmodule

// File: rtl/bcg_order.sv
module bcg_order
    import bcg_pkg::*;
(
    input  burst_desc_t       desc,
    input  logic [PAIR_W-1:0] pair,
    output logic [OFF_W-1:0]  offs [LANES]
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [OFF_W-1:0] beat;
        always_comb begin
            beat    = OFF_W'(pair) * OFF_W'(LANES) + OFF_W'(g);
            offs[g] = desc.ilv ? ilv_off(desc.start, beat) : seq_off(desc.start, beat);
        end
    end
endmodule

// File: rtl/ddr_burst_colgen.sv
module ddr_burst_colgen
    import bcg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [OFF_W-1:0]  cmd_col,
    input  logic              cmd_a10,
    input  logic              cmd_a12,
    input  logic [1:0]        cfg_bl_mode,
    input  logic              cfg_interleave,
    output logic              burst_active,
    output logic [PAIR_W-1:0] pair_idx,
    output logic              last_pair,
    output logic [CNT_W-1:0]  beat_count,
    output logic [OFF_W-1:0]  off_even,
    output logic [OFF_W-1:0]  off_odd,
    output logic              ap_out,
    output logic              write_burst,
    output logic              cmd_err
);
    burst_desc_t      desc_new, desc_cur;
    logic [OFF_W-1:0] offs [LANES];

    bcg_decode u_dec (
        .is_write(cmd_write), .col(cmd_col), .a10(cmd_a10), .a12(cmd_a12),
        .bl_mode(cfg_bl_mode), .ilv(cfg_interleave), .desc(desc_new)
    );

    bcg_seq u_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .desc_in(desc_new),
        .active(burst_active), .pair(pair_idx), .last(last_pair),
        .err(cmd_err), .desc_q(desc_cur)
    );

    bcg_order u_ord (.desc(desc_cur), .pair(pair_idx), .offs(offs));

    assign off_even    = offs[0];
    assign off_odd     = offs[1];
    assign ap_out      = last_pair && desc_cur.ap;
    assign write_burst = burst_active && desc_cur.wr;
    assign beat_count  = !burst_active ? '0 :
                         (desc_cur.len8 ? CNT_W'(BEATS_LONG) : CNT_W'(BEATS_SHORT));

    assert_ap_on_last_R7: assert property (@(posedge clk) disable iff (rst)
        ap_out |-> (last_pair && burst_active));

    assert_distinct_beats_R4: assert property (@(posedge clk) disable iff (rst)
        burst_active |-> (off_even != off_odd));

    assert_write_aligned_R6: assert property (@(posedge clk) disable iff (rst)
        (write_burst && pair_idx == '0) |-> (off_even[1:0] == 2'b00));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !burst_active |-> (!ap_out && !last_pair && beat_count == '0));
endmodule

// File: tb/ddr_burst_colgen_tb_top.sv
module ddr_burst_colgen_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 0, cmd_write = 0, cmd_a10 = 0, cmd_a12 = 0, cfg_interleave = 0;
    logic [2:0] cmd_col = 0;
    logic [1:0] cfg_bl_mode = 0;
    logic burst_active, last_pair, ap_out, write_burst, cmd_err;
    logic [1:0] pair_idx;
    logic [3:0] beat_count;
    logic [2:0] off_even, off_odd;

    int n_chk = 0, n_bad = 0, cyc = 0;

    // reference model state
    bit m_act, m_len8, m_ilv, m_wr, m_ap, m_err;
    int m_pair;
    bit [2:0] m_start;

    always #2 clk = ~clk;

    ddr_burst_colgen dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_col(cmd_col), .cmd_a10(cmd_a10), .cmd_a12(cmd_a12),
        .cfg_bl_mode(cfg_bl_mode), .cfg_interleave(cfg_interleave),
        .burst_active(burst_active), .pair_idx(pair_idx), .last_pair(last_pair),
        .beat_count(beat_count), .off_even(off_even), .off_odd(off_odd),
        .ap_out(ap_out), .write_burst(write_burst), .cmd_err(cmd_err)
    );

    function automatic bit [2:0] exp_off(bit [2:0] s, int b, bit ilv, bit wr);
        bit [2:0] bb = 3'(b);
        bit [2:0] st = wr ? {s[2], 2'b00} : s;
        bit [1:0] lo;
        if (!wr && ilv) return st ^ bb;
        lo = st[1:0] + bb[1:0];
        return {st[2] ^ bb[2], lo};
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    task automatic check_outputs();
        bit last = m_act && (m_pair == (m_len8 ? 3 : 1));
        string otag = m_wr ? "R6" : (m_ilv ? "R5" : "R4");
        chk("R2 active", burst_active, m_act);
        chk("R9 cmd_err", cmd_err, m_err);
        chk("R7 ap_out", ap_out, last && m_ap);
        chk("R3/R10 beat_count", beat_count, m_act ? (m_len8 ? 8 : 4) : 0);
        chk("R2 last_pair", last_pair, last);
        if (m_act) begin
            chk("R2/R8 pair_idx", pair_idx, m_pair);
            chk("R10 write_burst", write_burst, m_wr);
            chk({otag, " off_even"}, off_even, exp_off(m_start, 2*m_pair, m_ilv, m_wr));
            chk({otag, " off_odd"}, off_odd, exp_off(m_start, 2*m_pair+1, m_ilv, m_wr));
        end
    endtask

    // one cycle: check at negedge, drive, advance model to the next posedge
    task automatic step(bit v, bit w, bit [2:0] col, bit a10, bit a12, bit [1:0] md, bit ilv);
        bit last, acc;
        @(negedge clk);
        cyc++;
        check_outputs();
        cmd_valid = v; cmd_write = w; cmd_col = col; cmd_a10 = a10;
        cmd_a12 = a12; cfg_bl_mode = md; cfg_interleave = ilv;
        last = m_act && (m_pair == (m_len8 ? 3 : 1));
        acc  = v && (!m_act || last);
        m_err = v && m_act && !last;
        if (acc) begin
            m_act = 1; m_pair = 0; m_wr = w; m_ap = a10; m_start = col;
            m_ilv = ilv;
            m_len8 = (md == 2'b00) ? 1'b1 : (md == 2'b10) ? 1'b0 : a12;
        end else if (m_act) begin
            if (last) begin m_act = 0; m_pair = 0; end
            else m_pair++;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5eed_0c01));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state observed before any command
        chk("R1 active", burst_active, 0);
        chk("R1 cmd_err", cmd_err, 0);
        chk("R1 ap_out", ap_out, 0);
        chk("R1 beat_count", beat_count, 0);
        // R4: BL8 read from 5, nibble wrap: 5 6 7 4 1 2 3 0
        step(1, 0, 3'd5, 0, 0, 2'b00, 0);
        step(0, 0, 0, 0, 0, 2'b10, 1);   // R10: config flips mid-burst
        step(0, 0, 0, 0, 0, 2'b10, 1);
        // R9: command on a non-last pair is dropped
        step(1, 1, 3'd3, 1, 1, 2'b00, 0);
        // R8: command on last pair, R6 write with interleave set, R7 ap
        step(1, 1, 3'd7, 1, 0, 2'b01, 1);
        step(0, 0, 0, 0, 0, 2'b00, 0);
        // R5: BC4 interleaved read from 6, back-to-back on last pair
        step(1, 0, 3'd6, 0, 1, 2'b10, 1);
        step(0, 0, 0, 0, 0, 2'b00, 0);
        step(1, 0, 3'd3, 1, 1, 2'b11, 0); // R3: OTF with A12=1
        repeat (5) step(0, 0, 0, 0, 0, 2'b00, 0);
        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 100) < 40, 1'($urandom), 3'($urandom), 1'($urandom),
                 1'($urandom), 2'($urandom), 1'($urandom));
        end
        repeat (6) step(0, 0, 0, 0, 0, 2'b00, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule